// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block sits behind a CAN protocol engine and files every received frame into a bank of message mailboxes. Each mailbox has a mode, an acceptance filter (mask and identifier), a status word and eight data bytes. When the protocol engine presents a frame, the allocator checks it against each mailbox's filter. It then picks the lowest-numbered receive mailbox that is both free and matching, and stores the identifier, RTR bit, DLC and payload there. It also sets that mailbox's ready flag, which appears in a global status word.

A mailbox in overwrite mode still takes a frame while it holds unread data, provided no free mailbox matches. In that case it replaces the old contents and raises an ignored flag to record the lost message. Software reads the mailboxes through a flat register window and frees any set of them with one write to a re-arm register.

The control is a three-state machine. In IDLE the block waits for a frame and `rx_ready` is high. The transition IDLE to LOOKUP happens on `rx_valid`, which captures the frame. LOOKUP chooses a target and goes to COMMIT on a hit, or back to IDLE on a miss, which drops the frame. COMMIT writes the chosen mailbox and returns to IDLE.

Top module: `can_rx_mailbox_alloc`

## Requirements
- R1: After reset every ready flag, ignored flag, mode, mask and identifier is zero, the global status word reads 0 and `rx_ready` is 1.
- R2: A frame is stored in the lowest-numbered mailbox that is in a receive mode, has its ready flag clear and accepts the frame's identifier.
- R3: A stored frame reads back as follows. The identifier word (mailbox offset 0x08) has bit 29 = 1 and bits 28:0 = identifier for an extended frame, or bit 29 = 0 and bits 28:18 = the low 11 identifier bits for a standard frame. The status word (offset 0x0C) has DLC in bits 19:16, RTR at bit 20 and ready at bit 23. Data-low (0x10) holds bytes 0..3 and data-high (0x14) holds bytes 4..7, with byte 0 = `rx_data[7:0]` in the least significant position.
- R4: A mailbox accepts a frame when (encoded frame identifier XOR mailbox identifier) AND mailbox mask (offset 0x04, bits 29:0) is zero. A zero mask therefore accepts every identifier.
- R5: When no free mailbox accepts a frame, the lowest accepting mailbox in overwrite mode that is already full takes the frame, replaces its contents and sets the ignored flag at status bit 24.
- R6: A frame that no mailbox can take is dropped, and every mailbox register and the global status word stay unchanged.
- R7: Writing a mask to the re-arm register (offset 0x004) clears the ready and ignored flags of every mailbox whose bit is set. Those mailboxes then become free for the next allocation.
- R8: Bit n of the global status word (offset 0x000) equals the ready flag of mailbox n.
- R9: The mode field is bits 26:24 of the mode word (offset 0x00), encoded 0 off, 1 receive, 2 receive with overwrite, 3 transmit, 4 consumer, 5 producer. Only modes 1 and 2 ever receive frames.
- R10: `rx_ready` is high only in IDLE. The transitions are IDLE to LOOKUP on `rx_valid`, LOOKUP to COMMIT on a hit or to IDLE on a miss, and COMMIT to IDLE. A frame accepted at one edge is visible in the registers after the second following edge.
- R11: A frame stored into an empty overwrite-mode mailbox leaves its ignored flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received frame is presented this cycle |
| rx_ready | output | 1 | Block is idle and will take a frame |
| rx_ext | input | 1 | Frame has a 29-bit identifier |
| rx_id | input | 29 | Identifier (low 11 bits for standard frames) |
| rx_rtr | input | 1 | Remote request frame |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Payload, byte 0 in bits 7:0 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address: 0x000 status, 0x004 re-arm, mailbox n at 0x100 + 0x20*n |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
A table of frames first fills empty mailboxes in order. Standard, extended, remote and maximum-length frames are mixed, so each identifier encoding and the byte order of the payload show up separately. The directed part is built to tell the selection rules apart:
- A filtered mailbox below an accept-all one shows whether the filter is honoured or the lowest index simply wins.
- Transmit and consumer mailboxes in the middle of the bank show whether non-receive modes are skipped.
- An overwrite mailbox is hit first while empty and then while full, which separates a normal store from an overwrite.
- A frame that nothing accepts shows whether a drop really leaves every mailbox untouched.
- A multi-bit re-arm followed by a new frame shows whether freed mailboxes return to the front of the search.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;

    typedef enum logic [2:0] {
        MB_OFF    = 3'd0,
        MB_RX     = 3'd1,
        MB_RX_OVR = 3'd2,
        MB_TX     = 3'd3,
        MB_CONS   = 3'd4,
        MB_PROD   = 3'd5
    } mb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_COMMIT = 2'd2
    } alloc_state_e;

    localparam int unsigned KEY_W    = 30;
    localparam int unsigned MODE_LSB = 24;
    localparam int unsigned DLC_LSB  = 16;
    localparam int unsigned RTR_BIT  = 20;
    localparam int unsigned RDY_BIT  = 23;
    localparam int unsigned IGN_BIT  = 24;
    localparam int unsigned STD_LSB  = 18;

    // word select inside one mailbox window (address bits 4:2)
    localparam logic [2:0] SUB_MODE = 3'd0;
    localparam logic [2:0] SUB_MASK = 3'd1;
    localparam logic [2:0] SUB_KEY  = 3'd2;
    localparam logic [2:0] SUB_STAT = 3'd3;
    localparam logic [2:0] SUB_DLO  = 3'd4;
    localparam logic [2:0] SUB_DHI  = 3'd5;

    // identifier word layout: bit 29 = extended, std id at 28:18
    function automatic logic [KEY_W-1:0] enc_key(input logic ext, input logic [28:0] id);
        if (ext)
            return {1'b1, id};
        return {1'b0, id[10:0], 18'b0};
    endfunction

endpackage

// File: rtl/can_mbx_select.sv
module can_mbx_select
    import can_mbx_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = 4
) (
    input  logic [KEY_W-1:0]              key,
    input  logic [NUM_MB-1:0][2:0]        mode,
    input  logic [NUM_MB-1:0]             rdy,
    input  logic [NUM_MB-1:0][KEY_W-1:0]  filt_id,
    input  logic [NUM_MB-1:0][KEY_W-1:0]  filt_mask,
    output logic                          hit,
    output logic                          ovr,
    output logic [IDX_W-1:0]              idx
);

    logic [NUM_MB-1:0] free_v;
    logic [NUM_MB-1:0] full_ovr_v;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_cand
        logic accepts;
        logic is_rx;
        assign accepts       = ((key ^ filt_id[i]) & filt_mask[i]) == '0;
        assign is_rx         = (mode[i] == MB_RX) || (mode[i] == MB_RX_OVR);
        assign free_v[i]     = accepts && is_rx && !rdy[i];
        assign full_ovr_v[i] = accepts && (mode[i] == MB_RX_OVR) && rdy[i];
    end

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] ovr_idx;

    always_comb begin
        free_idx = '0;
        ovr_idx  = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (free_v[i])
                free_idx = IDX_W'(i);
            if (full_ovr_v[i])
                ovr_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (|free_v) begin
            hit = 1'b1;
            ovr = 1'b0;
            idx = free_idx;
        end else if (|full_ovr_v) begin
            hit = 1'b1;
            ovr = 1'b1;
            idx = ovr_idx;
        end else begin
            hit = 1'b0;
            ovr = 1'b0;
            idx = '0;
        end
    end

endmodule

// File: rtl/can_mbx_bank.sv
module can_mbx_bank
    import can_mbx_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [2:0]                    cfg_sub,
    input  logic [KEY_W-1:0]              cfg_wdata,
    input  logic                          rearm_we,
    input  logic [NUM_MB-1:0]             rearm_mask,
    input  logic                          st_we,
    input  logic [IDX_W-1:0]              st_idx,
    input  logic                          st_ovr,
    input  logic [KEY_W-1:0]              st_key,
    input  logic                          st_rtr,
    input  logic [3:0]                    st_dlc,
    input  logic [63:0]                   st_data,
    output logic [NUM_MB-1:0][2:0]        mode,
    output logic [NUM_MB-1:0][KEY_W-1:0]  filt_mask,
    output logic [NUM_MB-1:0][KEY_W-1:0]  filt_id,
    output logic [NUM_MB-1:0]             rdy,
    output logic [NUM_MB-1:0]             ign,
    output logic [NUM_MB-1:0]             rtr,
    output logic [NUM_MB-1:0][3:0]        dlc,
    output logic [NUM_MB-1:0][63:0]       data
);

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic [2:0]       mode_q;
        logic [KEY_W-1:0] mask_q;
        logic [KEY_W-1:0] id_q;
        logic             rdy_q;
        logic             ign_q;
        logic             rtr_q;
        logic [3:0]       dlc_q;
        logic [63:0]      data_q;
        logic             cfg_hit;
        logic             st_hit;

        assign cfg_hit = cfg_we && (cfg_idx == IDX_W'(i));
        assign st_hit  = st_we && (st_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q <= MB_OFF;
                mask_q <= '0;
                id_q   <= '0;
                rdy_q  <= 1'b0;
                ign_q  <= 1'b0;
                rtr_q  <= 1'b0;
                dlc_q  <= '0;
                data_q <= '0;
            end else begin
                if (cfg_hit) begin
                    unique case (cfg_sub)
                        SUB_MODE: mode_q <= cfg_wdata[MODE_LSB +: 3];
                        SUB_MASK: mask_q <= cfg_wdata;
                        SUB_KEY:  id_q   <= cfg_wdata;
                        default:  ;
                    endcase
                end
                if (rearm_we && rearm_mask[i]) begin
                    rdy_q <= 1'b0;
                    ign_q <= 1'b0;
                end
                // a frame store takes precedence over same-cycle software writes
                if (st_hit) begin
                    id_q   <= st_key;
                    rtr_q  <= st_rtr;
                    dlc_q  <= st_dlc;
                    data_q <= st_data;
                    rdy_q  <= 1'b1;
                    ign_q  <= st_ovr;
                end
            end
        end

        assign mode[i]      = mode_q;
        assign filt_mask[i] = mask_q;
        assign filt_id[i]   = id_q;
        assign rdy[i]       = rdy_q;
        assign ign[i]       = ign_q;
        assign rtr[i]       = rtr_q;
        assign dlc[i]       = dlc_q;
        assign data[i]      = data_q;
    end

endmodule

// File: rtl/can_rx_mailbox_alloc.sv
module can_rx_mailbox_alloc
    import can_mbx_pkg::*;
#(
    parameter int NUM_MB  = 16,
    parameter int MB_BASE = 256,
    localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
    localparam int ADDR_W = $clog2(MB_BASE + NUM_MB * 32 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_ext,
    input  logic [28:0]       rx_id,
    input  logic              rx_rtr,
    input  logic [3:0]        rx_dlc,
    input  logic [63:0]       rx_data,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    localparam logic [ADDR_W-1:0] A_GSTAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_REARM = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] MB_LO   = ADDR_W'(MB_BASE);
    localparam logic [ADDR_W-1:0] MB_HI   = ADDR_W'(MB_BASE + NUM_MB * 32);

    alloc_state_e state_q, state_d;

    logic [KEY_W-1:0] key_q;
    logic             rtr_q;
    logic [3:0]       dlc_q;
    logic [63:0]      data_q;
    logic [IDX_W-1:0] idx_q;
    logic             ovr_q;

    logic             sel_hit;
    logic             sel_ovr;
    logic [IDX_W-1:0] sel_idx;
    logic             st_we;

    logic [NUM_MB-1:0][2:0]       mb_mode;
    logic [NUM_MB-1:0][KEY_W-1:0] mb_mask;
    logic [NUM_MB-1:0][KEY_W-1:0] mb_id;
    logic [NUM_MB-1:0]            mb_rdy;
    logic [NUM_MB-1:0]            mb_ign;
    logic [NUM_MB-1:0]            mb_rtr;
    logic [NUM_MB-1:0][3:0]       mb_dlc;
    logic [NUM_MB-1:0][63:0]      mb_data;

    // ---- register decode ----
    logic              in_mb;
    logic [ADDR_W-1:0] mb_off;
    logic [IDX_W-1:0]  mb_idx;
    logic [2:0]        mb_sub;
    logic              cfg_we;
    logic              rearm_we;
    logic              unused_bits;

    assign in_mb       = (reg_addr >= MB_LO) && (reg_addr < MB_HI);
    assign mb_off      = reg_addr - MB_LO;
    assign mb_idx      = IDX_W'(mb_off >> 5);
    assign mb_sub      = mb_off[4:2];
    assign cfg_we      = reg_we && in_mb;
    assign rearm_we    = reg_we && (reg_addr == A_REARM);
    assign unused_bits = ^{reg_wdata[31:30], mb_off[1:0]};

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---- next state and outputs ----
    always_comb begin
        state_d  = state_q;
        rx_ready = 1'b0;
        st_we    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rx_ready = 1'b1;
                if (rx_valid)
                    state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                state_d = sel_hit ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                st_we   = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---- frame hold and selection capture ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            rtr_q  <= 1'b0;
            dlc_q  <= '0;
            data_q <= '0;
            idx_q  <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && rx_valid) begin
                key_q  <= enc_key(rx_ext, rx_id);
                rtr_q  <= rx_rtr;
                dlc_q  <= rx_dlc;
                data_q <= rx_data;
            end
            if (state_q == ST_LOOKUP) begin
                idx_q <= sel_idx;
                ovr_q <= sel_ovr;
            end
        end
    end

    can_mbx_select #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_select (
        .key       (key_q),
        .mode      (mb_mode),
        .rdy       (mb_rdy),
        .filt_id   (mb_id),
        .filt_mask (mb_mask),
        .hit       (sel_hit),
        .ovr       (sel_ovr),
        .idx       (sel_idx)
    );

    can_mbx_bank #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (mb_idx),
        .cfg_sub    (mb_sub),
        .cfg_wdata  (reg_wdata[KEY_W-1:0]),
        .rearm_we   (rearm_we),
        .rearm_mask (reg_wdata[NUM_MB-1:0]),
        .st_we      (st_we),
        .st_idx     (idx_q),
        .st_ovr     (ovr_q),
        .st_key     (key_q),
        .st_rtr     (rtr_q),
        .st_dlc     (dlc_q),
        .st_data    (data_q),
        .mode       (mb_mode),
        .filt_mask  (mb_mask),
        .filt_id    (mb_id),
        .rdy        (mb_rdy),
        .ign        (mb_ign),
        .rtr        (mb_rtr),
        .dlc        (mb_dlc),
        .data       (mb_data)
    );

    // ---- read mux ----
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_GSTAT) begin
            reg_rdata[NUM_MB-1:0] = mb_rdy;
        end else if (in_mb) begin
            unique case (mb_sub)
                SUB_MODE: reg_rdata[MODE_LSB +: 3] = mb_mode[mb_idx];
                SUB_MASK: reg_rdata[KEY_W-1:0]     = mb_mask[mb_idx];
                SUB_KEY:  reg_rdata[KEY_W-1:0]     = mb_id[mb_idx];
                SUB_STAT: begin
                    reg_rdata[DLC_LSB +: 4] = mb_dlc[mb_idx];
                    reg_rdata[RTR_BIT]      = mb_rtr[mb_idx];
                    reg_rdata[RDY_BIT]      = mb_rdy[mb_idx];
                    reg_rdata[IGN_BIT]      = mb_ign[mb_idx];
                end
                SUB_DLO:  reg_rdata = mb_data[mb_idx][31:0];
                SUB_DHI:  reg_rdata = mb_data[mb_idx][63:32];
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/can_rx_mailbox_alloc_chk.sv
module can_rx_mailbox_alloc_chk
    import can_mbx_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input alloc_state_e           state,
    input logic                   rx_valid,
    input logic                   rx_ready,
    input logic                   sel_hit,
    input logic                   sel_ovr,
    input logic [IDX_W-1:0]       sel_idx,
    input logic [IDX_W-1:0]       idx_q,
    input logic [NUM_MB-1:0][2:0] mode,
    input logic [NUM_MB-1:0]      rdy,
    input logic                   rearm_we,
    input logic [NUM_MB-1:0]      rearm_mask
);

    // R2: at most one mailbox fills per cycle
    p_single_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rdy & ~$past(rdy)) <= 1);

    // R2: the committed mailbox shows ready afterwards
    p_commit_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> rdy[$past(idx_q)]);

    // R9: only receive modes are ever chosen
    p_rx_mode_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && sel_hit) |->
            (mode[sel_idx] == MB_RX || mode[sel_idx] == MB_RX_OVR));

    // R5: overwrite only targets a full overwrite-mode mailbox
    p_overwrite_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && sel_hit && sel_ovr) |->
            (mode[sel_idx] == MB_RX_OVR && rdy[sel_idx]));

    // R6: a miss fills nothing
    p_drop_no_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && !sel_hit) |=> ((rdy & ~$past(rdy)) == '0));

    // R7: re-armed mailboxes read not ready
    p_rearm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_we && state != ST_COMMIT) |=> ((rdy & $past(rearm_mask)) == '0));

    // R10: busy right after a frame is taken
    p_busy_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> !rx_ready);

endmodule

bind can_rx_mailbox_alloc can_rx_mailbox_alloc_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .sel_hit    (sel_hit),
    .sel_ovr    (sel_ovr),
    .sel_idx    (sel_idx),
    .idx_q      (idx_q),
    .mode       (mb_mode),
    .rdy        (mb_rdy),
    .rearm_we   (rearm_we),
    .rearm_mask (reg_wdata[NUM_MB-1:0])
);

// File: tb/can_rx_mailbox_alloc_test.sv
module can_rx_mailbox_alloc_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic        rtr;
        logic [3:0]  dlc;
        logic [63:0] data;
        logic [3:0]  mb;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 29'h1FFFF7A5, 1'b0, 4'd8,  64'h8877665544332211, 4'd0},
        '{1'b1, 29'h1ABCDEF1, 1'b0, 4'd4,  64'h00000000DEADBEEF, 4'd1},
        '{1'b0, 29'h00000001, 1'b1, 4'd0,  64'h0000000000000000, 4'd2},
        '{1'b1, 29'h1FFFFFFF, 1'b1, 4'd15, 64'hFEDCBA9876543210, 4'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic              rx_ready;
    logic              rx_ext = 1'b0;
    logic [28:0]       rx_id = '0;
    logic              rx_rtr = 1'b0;
    logic [3:0]        rx_dlc = '0;
    logic [63:0]       rx_data = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    can_rx_mailbox_alloc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_ext    (rx_ext),
        .rx_id     (rx_id),
        .rx_rtr    (rx_rtr),
        .rx_dlc    (rx_dlc),
        .rx_data   (rx_data),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int mba(input int i, input int sub);
        return 256 + i * 32 + sub * 4;
    endfunction

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = ADDR_W'(addr);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        reg_addr = ADDR_W'(addr);
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic ext, input logic [28:0] id, input logic rtr,
                        input logic [3:0] dlc, input logic [63:0] data);
        @(negedge clk);
        rx_ext   = ext;
        rx_id    = id;
        rx_rtr   = rtr;
        rx_dlc   = dlc;
        rx_data  = data;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R10 busy after take", {31'b0, rx_ready}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_key(input logic ext, input logic [28:0] id);
        if (ext)
            return {3'b001, id};
        return {3'b000, id[10:0], 18'b0};
    endfunction

    task automatic check_mb(input int i, input logic ext, input logic [28:0] id, input logic rtr,
                            input logic [3:0] dlc, input logic [63:0] data, input logic ign);
        logic [31:0] v;
        rd(mba(i, 2), v);
        chk("R3 identifier word", v, exp_key(ext, id));
        rd(mba(i, 3), v);
        chk("R3 status word", v, (32'(ign) << 24) | (32'd1 << 23) | (32'(rtr) << 20) | (32'(dlc) << 16));
        rd(mba(i, 4), v);
        chk("R3 data low", v, data[31:0]);
        rd(mba(i, 5), v);
        chk("R3 data high", v, data[63:32]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] gexp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
        rd(0, v);        chk("R1 global status", v, 32'd0);
        rd(mba(0, 0), v); chk("R1 mode", v, 32'd0);
        rd(mba(5, 3), v); chk("R1 status", v, 32'd0);
        rd(mba(9, 1), v); chk("R1 mask", v, 32'd0);

        // configure: 0..9 receive, 10 transmit, 11 overwrite, 12 consumer, rest off
        for (int i = 0; i < 10; i++) wr(mba(i, 0), 32'h0100_0000);
        wr(mba(10, 0), 32'h0300_0000);
        wr(mba(11, 0), 32'h0200_0000);
        wr(mba(12, 0), 32'h0400_0000);
        rd(mba(11, 0), v); chk("R9 mode readback", v, 32'h0200_0000);

        // table walk: R2, R3, R4 (zero mask), R8
        gexp = 0;
        for (int k = 0; k < 4; k++) begin
            send(VECS[k].ext, VECS[k].id, VECS[k].rtr, VECS[k].dlc, VECS[k].data);
            check_mb(int'(VECS[k].mb), VECS[k].ext, VECS[k].id, VECS[k].rtr,
                     VECS[k].dlc, VECS[k].data, 1'b0);
            gexp = gexp | (32'd1 << VECS[k].mb);
            rd(0, v); chk("R8 global status after table frame", v, gexp);
        end

        // R4: filtered mailbox 4 rejects a mismatch, accepts an exact match
        wr(mba(4, 1), 32'h3FFF_FFFF);
        wr(mba(4, 2), {3'b001, 29'h00ABCDEF});
        send(1'b1, 29'h00ABCDE0, 1'b0, 4'd2, 64'h0000_0000_0000_5A5A);
        rd(0, v); chk("R4 mismatch skips filtered mailbox", v, 32'h0000_002F);
        check_mb(5, 1'b1, 29'h00ABCDE0, 1'b0, 4'd2, 64'h0000_0000_0000_5A5A, 1'b0);
        send(1'b1, 29'h00ABCDEF, 1'b0, 4'd1, 64'h0000_0000_0000_00C3);
        rd(0, v); chk("R4 match fills filtered mailbox", v, 32'h0000_003F);
        check_mb(4, 1'b1, 29'h00ABCDEF, 1'b0, 4'd1, 64'h0000_0000_0000_00C3, 1'b0);

        // R2: fill 6..9 in order
        gexp = 32'h3F;
        for (int k = 6; k < 10; k++) begin
            send(1'b0, 29'(k), 1'b0, 4'(k), {56'h0, 8'(k)});
            gexp = gexp | (32'd1 << k);
            rd(0, v); chk("R2 lowest free mailbox", v, gexp);
        end

        // R9 and R11: transmit mailbox 10 skipped, empty overwrite mailbox 11 filled cleanly
        send(1'b0, 29'h155, 1'b0, 4'd3, 64'h0000_0000_0011_2233);
        rd(0, v); chk("R9 transmit mode skipped", v, 32'h0000_0BFF);
        check_mb(11, 1'b0, 29'h155, 1'b0, 4'd3, 64'h0000_0000_0011_2233, 1'b0);

        // R5: no free mailbox, full overwrite mailbox takes the frame
        send(1'b1, 29'h0123_4567, 1'b1, 4'd6, 64'hAABB_CCDD_EEFF_0011);
        rd(0, v); chk("R9 consumer/off modes never fill", v, 32'h0000_0BFF);
        check_mb(11, 1'b1, 29'h0123_4567, 1'b1, 4'd6, 64'hAABB_CCDD_EEFF_0011, 1'b1);

        // R6: overwrite mailbox now filters, nothing accepts, frame dropped
        wr(mba(11, 1), 32'h3FFF_FFFF);
        send(1'b0, 29'h0AA, 1'b0, 4'd8, 64'h1111_2222_3333_4444);
        rd(0, v); chk("R6 drop leaves status", v, 32'h0000_0BFF);
        check_mb(11, 1'b1, 29'h0123_4567, 1'b1, 4'd6, 64'hAABB_CCDD_EEFF_0011, 1'b1);
        rd(mba(0, 4), v); chk("R6 drop leaves mailbox 0", v, 32'h4433_2211);

        // R7: re-arm mailboxes 0 and 11 in one write
        wr(4, 32'h0000_0801);
        rd(0, v); chk("R7 re-arm clears ready bits", v, 32'h0000_03FE);
        rd(mba(11, 3), v); chk("R7 re-arm clears ready and ignored", v & 32'h0180_0000, 32'd0);
        send(1'b0, 29'h3C3, 1'b0, 4'd5, 64'h0000_0099_8877_6655);
        rd(0, v); chk("R7 freed mailbox 0 reused first", v, 32'h0000_03FF);
        check_mb(0, 1'b0, 29'h3C3, 1'b0, 4'd5, 64'h0000_0099_8877_6655, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule